// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen 32-bit architectural registers of a processor core whose register set depends on the current operating mode. Each access names an architectural register with a 4-bit index. The block turns that index, together with a 5-bit mode word, into one of 31 physical registers. Registers 0 to 7 and the program counter (register 15) are common to every mode. Registers 8 to 12 have a second set used only in fast-interrupt mode. The stack pointer (13) and link register (14) have a separate pair for each exception mode, and user and system mode share one pair.

Each exception mode also has one saved-status register. The exception-entry logic writes it while the mode input already shows the exception being entered. Two combinational read ports and one write port serve the general registers, and one read port and one write port serve the saved status. A user-bank override lets privileged code reach the user copies of registers 8 to 14. Program-counter stepping, exception priority and instruction decode are handled elsewhere.

Top module: `banked_regfile`

## Requirements
- R1: Indices 0 to 7 address a single physical copy each; a value written in any mode is read back unchanged in every other mode.
- R2: Indices 8 to 12 address a copy shared by all modes except fast interrupt (mode 5'b10001), which reads and writes a separate set of five.
- R3: Indices 13 and 14 address one pair per bank: user/system, supervisor, abort, undefined, interrupt and fast interrupt. User (5'b10000) and system (5'b11111) see the same pair.
- R4: Index 15 addresses one program-counter copy shared by every mode.
- R5: Mode codes are 10000 user, 10001 fast interrupt, 10010 interrupt, 10011 supervisor, 10111 abort, 11011 undefined, 11111 system. Any other code banks exactly like user.
- R6: In each of the five exception modes, a write strobe on the saved-status port stores into that mode's own saved-status register. The saved-status read port returns the current mode's copy.
- R7: In user, system or an unlisted mode, saved-status writes leave every saved-status copy unchanged, and the saved-status read returns zero.
- R8: While the override input is high, indices 8 to 14 resolve to the user copies for reads and writes in every mode.
- R9: A read that addresses the same physical register as a write in the same cycle returns the new write data (write-first). This holds for both general read ports and for the saved-status port.
- R10: A low rst_n sampled at a clock edge clears every physical register and every saved-status copy to zero.
- R11: Writes take effect at the rising clock edge. Read ports are combinational from the stored state plus the bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 5 | Current processor mode code |
| usr_ovr_i | input | 1 | Force indices 8 to 14 onto the user copies |
| rd_a_idx_i | input | 4 | Read port A architectural index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B architectural index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General write strobe |
| wr_idx_i | input | 4 | Write architectural index |
| wr_data_i | input | 32 | Write data |
| sav_wr_en_i | input | 1 | Saved-status write strobe |
| sav_wr_data_i | input | 32 | Saved-status write data |
| sav_rd_data_o | output | 32 | Saved status of the current mode |

## Verification
The bench builds the block with its default 32-bit data width and the fixed sixteen-register, seven-mode banking. The data width does not affect which register is chosen, so all 31 physical registers and all five saved-status copies can be reached within a few hundred cycles. That covers every pairing of a write in one mode with a read in another, including unlisted mode codes and the override in fast-interrupt mode. A long random phase mixes modes, overrides, same-cycle write/read collisions and a mid-run reset against the behavioural model.

// File: rtl/bankreg_pkg.sv
// Package: shared constants, mode codes and decoded-mode type for the
// mode-banked register file. Assumes a 16-entry architectural view.
package bankreg_pkg;
    localparam int MODE_W       = 5;
    localparam int IDX_W        = 4;
    localparam int N_ARCH       = 16;
    localparam int N_LOW        = 8;   // never-banked low registers
    localparam int N_MID        = 5;   // registers banked only for fast interrupt
    localparam int N_SPLR_BANKS = 6;   // user/sys + five exception modes
    localparam int N_SAV        = 5;   // one saved status per exception mode
    localparam int N_PHYS       = N_LOW + 2 * N_MID + 2 * N_SPLR_BANKS + 1;
    localparam int PHYS_W       = $clog2(N_PHYS);
    localparam int BANK_W       = $clog2(N_SPLR_BANKS);
    localparam int SAV_W        = $clog2(N_SAV);

    typedef logic [PHYS_W-1:0] phys_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // Physical layout bases.
    localparam phys_t BASE_MID  = phys_t'(N_LOW);
    localparam phys_t BASE_FMID = phys_t'(N_LOW + N_MID);
    localparam phys_t BASE_SPLR = phys_t'(N_LOW + 2 * N_MID);
    localparam phys_t PHYS_PC   = phys_t'(N_PHYS - 1);

    // Architectural index boundaries.
    localparam idx_t IDX_MID_LO  = idx_t'(N_LOW);
    localparam idx_t IDX_SPLR_LO = idx_t'(N_LOW + N_MID);
    localparam idx_t IDX_PC      = idx_t'(N_ARCH - 1);

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } mode_e;

    typedef struct packed {
        logic [BANK_W-1:0] splr_bank; // 0 user/sys, 1 svc, 2 abt, 3 und, 4 irq, 5 fiq
        logic              fiq;
        logic              sav_ok;
        logic [SAV_W-1:0]  sav_sel;
    } mode_info_t;
endpackage

// File: rtl/bankreg_mode_dec.sv
// Module: bankreg_mode_dec
// Turns the 5-bit mode code into bank selections. Any unlisted code
// decodes the same way as user mode. Purely combinational.
module bankreg_mode_dec
    import bankreg_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output mode_info_t        info_o
);
    // Select stack/link bank, fast-interrupt flag and saved-status slot.
    always_comb begin
        info_o = '0;
        case (mode_i)
            MODE_SVC: begin
                info_o.splr_bank = BANK_W'(1);
                info_o.sav_ok    = 1'b1;
                info_o.sav_sel   = SAV_W'(0);
            end
            MODE_ABT: begin
                info_o.splr_bank = BANK_W'(2);
                info_o.sav_ok    = 1'b1;
                info_o.sav_sel   = SAV_W'(1);
            end
            MODE_UND: begin
                info_o.splr_bank = BANK_W'(3);
                info_o.sav_ok    = 1'b1;
                info_o.sav_sel   = SAV_W'(2);
            end
            MODE_IRQ: begin
                info_o.splr_bank = BANK_W'(4);
                info_o.sav_ok    = 1'b1;
                info_o.sav_sel   = SAV_W'(3);
            end
            MODE_FIQ: begin
                info_o.splr_bank = BANK_W'(5);
                info_o.fiq       = 1'b1;
                info_o.sav_ok    = 1'b1;
                info_o.sav_sel   = SAV_W'(4);
            end
            default: info_o = '0; // user, system and unlisted codes
        endcase
    end
endmodule

// File: rtl/bankreg_addr_map.sv
// Module: bankreg_addr_map
// Maps an architectural index plus decoded mode to a physical register
// number. The override forces indices 8..14 onto the user copies.
module bankreg_addr_map
    import bankreg_pkg::*;
(
    input  idx_t       idx_i,
    input  mode_info_t info_i,
    input  logic       ovr_i,
    output phys_t      phys_o
);
    logic              fiq_sel;
    logic [BANK_W-1:0] bank;

    // Resolve the effective bank after the user override.
    always_comb begin
        fiq_sel = info_i.fiq && !ovr_i;
        bank    = ovr_i ? '0 : info_i.splr_bank;
    end

    // Region select: low shared, mid (fiq-banked), stack/link pairs, program counter.
    always_comb begin
        if (idx_i < IDX_MID_LO)
            phys_o = phys_t'(idx_i);
        else if (idx_i < IDX_SPLR_LO)
            phys_o = (fiq_sel ? BASE_FMID : BASE_MID) + phys_t'(idx_i - IDX_MID_LO);
        else if (idx_i < IDX_PC)
            phys_o = BASE_SPLR + (phys_t'(bank) << 1) + phys_t'(idx_i - IDX_SPLR_LO);
        else
            phys_o = PHYS_PC;
    end
endmodule

// File: rtl/bankreg_store.sv
// Module: bankreg_store
// Physical storage: N_PHYS words, one write port, N_RD combinational read
// ports with write-first bypass. Assumes addresses are below N_PHYS.
module bankreg_store
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N_RD   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  phys_t                         waddr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    input  logic [N_RD-1:0][PHYS_W-1:0]   raddr_i,
    output logic [N_RD-1:0][DATA_W-1:0]   rdata_o
);
    logic [DATA_W-1:0] regs [N_PHYS];

    for (genvar g = 0; g < N_PHYS; g++) begin : g_reg
        // One physical register: cleared by reset, loaded on matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we_i && waddr_i == phys_t'(g))
                regs[g] <= wdata_i;
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        // Read port with same-cycle write forwarding.
        always_comb begin
            if (we_i && waddr_i == raddr_i[p])
                rdata_o[p] = wdata_i;
            else
                rdata_o[p] = regs[raddr_i[p]];
        end
    end

    // R11: every write lands inside the physical array.
    a_r11_waddr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (waddr_i <= PHYS_PC));
endmodule

// File: rtl/bankreg_sav.sv
// Module: bankreg_sav
// Saved-status copies, one per exception mode. Writes outside an exception
// mode are dropped; reads there return zero. Write-first bypass.
module bankreg_sav
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_info_t        info_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] sav [N_SAV];

    for (genvar s = 0; s < N_SAV; s++) begin : g_sav
        // One saved-status copy, loaded only in its own exception mode.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sav[s] <= '0;
            else if (we_i && info_i.sav_ok && info_i.sav_sel == SAV_W'(s))
                sav[s] <= wdata_i;
        end
    end

    // Current mode's copy, forwarded write data, or zero outside exceptions.
    always_comb begin
        if (!info_i.sav_ok)
            rdata_o = '0;
        else if (we_i)
            rdata_o = wdata_i;
        else
            rdata_o = sav[info_i.sav_sel];
    end
endmodule

// File: rtl/banked_regfile.sv
// Module: banked_regfile (top)
// Sixteen architectural registers resolved to 31 physical ones by mode,
// two read ports, one write port, and per-exception saved status.
// Assumes the mode input is stable for the whole cycle of an access.
module banked_regfile
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic              usr_ovr_i,
    input  logic [3:0]        rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [3:0]        rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              sav_wr_en_i,
    input  logic [DATA_W-1:0] sav_wr_data_i,
    output logic [DATA_W-1:0] sav_rd_data_o
);
    localparam int N_RD   = 2;
    localparam int N_PORT = N_RD + 1; // read ports then the write port

    mode_info_t                          info;
    logic [N_PORT-1:0][IDX_W-1:0]        port_idx;
    logic [N_PORT-1:0][PHYS_W-1:0]       port_phys;
    logic [N_RD-1:0][DATA_W-1:0]         rd_data;

    bankreg_mode_dec u_dec (
        .mode_i (mode_i),
        .info_o (info)
    );

    // Gather the architectural indices of all ports.
    always_comb begin
        port_idx[0] = rd_a_idx_i;
        port_idx[1] = rd_b_idx_i;
        port_idx[2] = wr_idx_i;
    end

    for (genvar p = 0; p < N_PORT; p++) begin : g_map
        bankreg_addr_map u_map (
            .idx_i  (port_idx[p]),
            .info_i (info),
            .ovr_i  (usr_ovr_i),
            .phys_o (port_phys[p])
        );
    end

    bankreg_store #(.DATA_W(DATA_W), .N_RD(N_RD)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en_i),
        .waddr_i (port_phys[N_RD]),
        .wdata_i (wr_data_i),
        .raddr_i (port_phys[N_RD-1:0]),
        .rdata_o (rd_data)
    );

    // Drive the read-data outputs.
    always_comb begin
        rd_a_data_o = rd_data[0];
        rd_b_data_o = rd_data[1];
    end

    bankreg_sav #(.DATA_W(DATA_W)) u_sav (
        .clk     (clk),
        .rst_n   (rst_n),
        .info_i  (info),
        .we_i    (sav_wr_en_i),
        .wdata_i (sav_wr_data_i),
        .rdata_o (sav_rd_data_o)
    );

    // R7: outside the five exception modes the saved status reads zero.
    a_r7_sav_zero_outside_exc: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_i inside {MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND})
        |-> (sav_rd_data_o == '0));

    // R6: a saved-status write in an exception mode is read back next cycle.
    a_r6_sav_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sav_wr_en_i && (mode_i inside {MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND}))
        |=> (($stable(mode_i) && !sav_wr_en_i) -> (sav_rd_data_o == $past(sav_wr_data_i))));

    // R1: a low register written in any mode reads back in the next cycle, any mode.
    a_r1_low_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i < 4'd8)
        |=> ((rd_a_idx_i == $past(wr_idx_i) && !wr_en_i) -> (rd_a_data_o == $past(wr_data_i))));

    // R4: the program counter is one copy across modes and overrides.
    a_r4_pc_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i == 4'd15)
        |=> ((rd_b_idx_i == 4'd15 && !wr_en_i) -> (rd_b_data_o == $past(wr_data_i))));

    // R9: same index, same cycle, same mode: port A sees the write data.
    a_r9_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && rd_a_idx_i == wr_idx_i) |-> (rd_a_data_o == wr_data_i));
endmodule

// File: tb/banked_regfile_tb_top.sv
// Bench: behavioural reference model compared on every clock.
module banked_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    mode = 5'b10000;
    logic          ovr = 1'b0;
    logic [3:0]    ra = '0, rb = '0, widx = '0;
    logic          we = 1'b0, swe = 1'b0;
    logic [DW-1:0] wd = '0, swd = '0;
    logic [DW-1:0] rda, rdb, srd;

    int n_chk = 0;
    int n_bad = 0;
    string ctx = "init";

    banked_regfile #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .usr_ovr_i(ovr),
        .rd_a_idx_i(ra), .rd_a_data_o(rda), .rd_b_idx_i(rb), .rd_b_data_o(rdb),
        .wr_en_i(we), .wr_idx_i(widx), .wr_data_i(wd),
        .sav_wr_en_i(swe), .sav_wr_data_i(swd), .sav_rd_data_o(srd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference state, kept per architectural meaning rather than per slot.
    logic [DW-1:0] m_low [8];
    logic [DW-1:0] m_mid [5];
    logic [DW-1:0] m_fiqmid [5];
    logic [DW-1:0] m_sp [6];
    logic [DW-1:0] m_lr [6];
    logic [DW-1:0] m_pc;
    logic [DW-1:0] m_sav [5];

    function automatic int owner(logic [4:0] m);
        case (m)
            5'b10011: return 1;
            5'b10111: return 2;
            5'b11011: return 3;
            5'b10010: return 4;
            5'b10001: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [DW-1:0] m_read(logic [3:0] i, logic [4:0] m, logic o);
        int b;
        b = o ? 0 : owner(m);
        if (i < 8) return m_low[i];
        if (i < 13) return (b == 5) ? m_fiqmid[i-8] : m_mid[i-8];
        if (i == 13) return m_sp[b];
        if (i == 14) return m_lr[b];
        return m_pc;
    endfunction

    task automatic m_write(logic [3:0] i, logic [4:0] m, logic o, logic [DW-1:0] d);
        int b;
        b = o ? 0 : owner(m);
        if (i < 8) m_low[i] = d;
        else if (i < 13) begin
            if (b == 5) m_fiqmid[i-8] = d; else m_mid[i-8] = d;
        end
        else if (i == 13) m_sp[b] = d;
        else if (i == 14) m_lr[b] = d;
        else m_pc = d;
    endtask

    task automatic m_clear();
        for (int i = 0; i < 8; i++) m_low[i] = '0;
        for (int i = 0; i < 5; i++) begin m_mid[i] = '0; m_fiqmid[i] = '0; m_sav[i] = '0; end
        for (int i = 0; i < 6; i++) begin m_sp[i] = '0; m_lr[i] = '0; end
        m_pc = '0;
    endtask

    function automatic string tag_of(logic [3:0] i, logic [4:0] m, logic o, logic byp);
        string t;
        if (byp) t = "R9";
        else if (o && i >= 8 && i <= 14) t = "R8";
        else if (i < 8) t = "R1";
        else if (i < 13) t = "R2";
        else if (i < 15) t = "R3";
        else t = "R4";
        if (owner(m) == 0 && m != 5'b10000 && m != 5'b11111) t = {t, "/R5"};
        return t;
    endfunction

    task automatic cmp(string t, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] mode=%b ovr=%0b: actual=%h expected=%h", t, ctx, mode, ovr, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare, then advance the model.
    task automatic step(logic [4:0] m, logic o, logic [3:0] a, logic [3:0] b,
                        logic w, logic [3:0] wi, logic [DW-1:0] wdv,
                        logic sw, logic [DW-1:0] swdv);
        logic [DW-1:0] ea, eb, es;
        int s;
        @(negedge clk);
        mode = m; ovr = o; ra = a; rb = b; we = w; widx = wi; wd = wdv; swe = sw; swd = swdv;
        #1;
        ea = (w && wi == a) ? wdv : m_read(a, m, o);
        eb = (w && wi == b) ? wdv : m_read(b, m, o);
        s  = owner(m) - 1;
        es = (s < 0) ? '0 : (sw ? swdv : m_sav[s]);
        cmp(tag_of(a, m, o, w && wi == a), rda, ea);
        cmp(tag_of(b, m, o, w && wi == b), rdb, eb);
        cmp((s < 0) ? "R7" : (sw ? "R9/R6" : "R6"), srd, es);
        if (w) m_write(wi, m, o, wdv);
        if (sw && s >= 0) m_sav[s] = swdv;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; we = 1'b0; swe = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_clear();
    endtask

    task automatic rd(logic [4:0] m, logic o, logic [3:0] a, logic [3:0] b);
        step(m, o, a, b, 1'b0, 4'd0, '0, 1'b0, '0);
    endtask

    task automatic wr(logic [4:0] m, logic o, logic [3:0] i, logic [DW-1:0] d);
        step(m, o, 4'd0, 4'd1, 1'b1, i, d, 1'b0, '0);
    endtask

    localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                           SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                           SYS = 5'b11111;

    initial begin
        logic [4:0] modes [7];
        modes = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS};
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        ctx = "R10 reset state";
        for (int i = 0; i < 16; i += 2) rd(SVC, 1'b0, 4'(i), 4'(i + 1));
        rd(FIQ, 1'b0, 4'd8, 4'd13);

        ctx = "R11 user writes all";
        for (int i = 0; i < 16; i++) wr(USR, 1'b0, 4'(i), 32'h1000_0000 + i);
        for (int i = 0; i < 16; i += 2) rd(USR, 1'b0, 4'(i), 4'(i + 1));

        ctx = "R2 R3 fiq bank";
        for (int i = 8; i < 15; i++) wr(FIQ, 1'b0, 4'(i), 32'hF100_0000 + i);
        for (int i = 8; i < 15; i++) rd(FIQ, 1'b0, 4'(i), 4'(i - 8));
        for (int i = 8; i < 15; i++) rd(USR, 1'b0, 4'(i), 4'd15);

        ctx = "R3 exception pairs";
        for (int k = 2; k < 6; k++) begin
            wr(modes[k], 1'b0, 4'd13, 32'h5500_0000 + k);
            wr(modes[k], 1'b0, 4'd14, 32'h1100_0000 + k);
        end
        for (int k = 0; k < 7; k++) rd(modes[k], 1'b0, 4'd13, 4'd14);
        wr(SYS, 1'b0, 4'd13, 32'h5151_0000);
        rd(USR, 1'b0, 4'd13, 4'd14);

        ctx = "R5 unlisted mode codes";
        rd(5'b00000, 1'b0, 4'd13, 4'd9);
        wr(5'b10110, 1'b0, 4'd14, 32'hBADC_0DE5);
        rd(USR, 1'b0, 4'd14, 4'd13);
        rd(5'b01111, 1'b0, 4'd14, 4'd10);

        ctx = "R8 user override";
        rd(FIQ, 1'b1, 4'd8, 4'd14);
        wr(FIQ, 1'b1, 4'd9, 32'h0E0E_0009);
        rd(USR, 1'b0, 4'd9, 4'd8);
        rd(FIQ, 1'b0, 4'd9, 4'd8);
        wr(IRQ, 1'b1, 4'd13, 32'h0E0E_0013);
        rd(USR, 1'b0, 4'd13, 4'd14);
        rd(IRQ, 1'b0, 4'd13, 4'd14);

        ctx = "R6 R7 saved status";
        for (int k = 1; k < 6; k++)
            step(modes[k], 1'b0, 4'd0, 4'd1, 1'b0, 4'd0, '0, 1'b1, 32'h5A00_0000 + k);
        for (int k = 0; k < 7; k++) rd(modes[k], 1'b0, 4'd2, 4'd3);
        step(SYS, 1'b0, 4'd0, 4'd1, 1'b0, 4'd0, '0, 1'b1, 32'hDEAD_0007);
        step(USR, 1'b0, 4'd0, 4'd1, 1'b0, 4'd0, '0, 1'b1, 32'hDEAD_0008);
        for (int k = 1; k < 6; k++) rd(modes[k], 1'b0, 4'd4, 4'd5);

        ctx = "R9 same-cycle forwarding";
        step(ABT, 1'b0, 4'd3, 4'd13, 1'b1, 4'd3, 32'hB0B0_0003, 1'b1, 32'hB0B0_5A5A);
        step(FIQ, 1'b0, 4'd10, 4'd10, 1'b1, 4'd10, 32'hB0B0_000A, 1'b0, '0);
        rd(ABT, 1'b0, 4'd3, 4'd13);

        ctx = "R10 mid-run reset";
        do_reset();
        for (int i = 0; i < 16; i += 2) rd(FIQ, 1'b0, 4'(i), 4'(i + 1));
        for (int k = 0; k < 7; k++) rd(modes[k], 1'b0, 4'd13, 4'd14);

        ctx = "random mix";
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] m;
            int pick;
            pick = int'($urandom_range(0, 8));
            m = (pick < 7) ? modes[pick] : 5'($urandom);
            step(m, ($urandom_range(0, 7) == 0), 4'($urandom), 4'($urandom),
                 ($urandom_range(0, 1) == 1), 4'($urandom), $urandom,
                 ($urandom_range(0, 5) == 0), $urandom);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog: actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule